// File: doc/BRIEF.md
# Punctured Rate-Selectable K=7 Viterbi Decoder

This block recovers the information bits of a convolutionally coded stream. The code has constraint length 7 and generator polynomials 171 and 133 (octal). Hard channel bits arrive one at a time, already punctured at one of five selectable code rates. An internal depuncturer rebuilds symbol pairs and marks the removed positions as erasures. A 64-state add-compare-select core with survivor register exchange then decodes the pairs. Each decoded bit emerges a fixed number of pairs after the pair that carried it.

Alongside the decoder, a channel error meter re-encodes the decoded bits. It compares each re-encoded symbol with the received, non-erased bit of the same position. The mismatches are summed over a programmable window of decoded bits, and the total is latched when the window closes. This gives a running estimate of the raw channel bit error rate for a receiver front end. Changing the selected rate restarts the decoder from a clean state.

Top module: `vit_k7_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` and `ber_done` are low and `ber_count` is zero.
- R2: `rate_sel` codes are 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 5/6 and 4 = 7/8; codes 5 to 7 act as 1/2. The kept first-generator (G1) bits per period are 1, 10, 101, 10101 and 1000101, and the kept second-generator (G2) bits are 1, 11, 110, 11010 and 1111010, with period position 0 leftmost. Within one period position the kept G1 bit is sent before the kept G2 bit. A removed bit is an erasure that adds no cost to any branch, and no rebuilt pair has both halves erased.
- R3: The encoder starts from the all-zero state. Generator taps apply with the MSB of each octal polynomial to the newest input bit.
- R4: With an error-free channel, the decoded stream equals the encoded information stream at every rate.
- R5: After a reset or clear, each completed pair from the (TB_DEPTH+1)-th onward raises `out_valid` for one cycle. That cycle is two clock cycles after the channel bit that completes the pair is accepted. `out_bit` is the information bit of the pair TB_DEPTH pairs earlier. No other cycle has `out_valid` high.
- R6: Isolated channel bit errors are corrected at rates 1/2 and 3/4: at most one error per 40 channel bits at 1/2, and one per 48 at 3/4. Path metrics stay below half their range.
- R7: One cycle after the `out_valid` of the last bit of a window, `ber_done` pulses for one cycle. `ber_count` then holds the number of positions in that window where the re-encoded bit differs from a received, non-erased bit. A window is `ber_window` decoded bits long.
- R8: `ber_count` keeps its value between window ends. A `ber_window` of 0 or 1 closes a window on every decoded bit.
- R9: A change of `rate_sel` clears the path metrics, the survivors, the depuncturing phase, the fill count and the error meter, and sets `ber_count` to zero. Outputs stay low on the next cycle, and decoding restarts as after reset.
- R10: A cycle with `in_valid` low has no effect on decoding or on the error meter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Code rate select |
| in_valid | input | 1 | Channel bit present this cycle |
| in_bit | input | 1 | Hard channel bit |
| ber_window | input | WIN_W | Error-meter window length in decoded bits |
| out_valid | output | 1 | Decoded bit valid pulse |
| out_bit | output | 1 | Decoded information bit |
| ber_done | output | 1 | Window closed, count updated |
| ber_count | output | WIN_W+2 | Channel bit mismatches in the last window |

## Verification
A wrong depuncturing phase or a wrong erasure flag feeds the add-compare-select core inconsistent branch costs. The decoded stream then drifts away from the source, and the mismatch shows at `out_bit` TB_DEPTH+1 pairs later; the next closing window shows an inflated `ber_count`. A corrupted path metric or survivor shows as wrong decoded bits within one traceback span. A misaligned re-encoder or received-pair delay line shows as a non-zero count on a clean channel at the first window end. The reference model predicts every cycle's `out_valid`, `out_bit`, `ber_done` and `ber_count`, so any timing slip is caught in the cycle it occurs.

// File: rtl/vit_k7_pkg.sv
package vit_k7_pkg;

    localparam int CONSTR_LEN = 7;
    localparam int NUM_STATES = 1 << (CONSTR_LEN - 1);
    localparam int STATE_W    = CONSTR_LEN - 1;

    // MSB of each tap vector multiplies the newest input bit
    localparam logic [6:0] TAPS_A = 7'b1111001;
    localparam logic [6:0] TAPS_B = 7'b1011011;

    typedef struct packed {
        logic a;
        logic b;
        logic era_a;
        logic era_b;
    } chan_pair_t;

    function automatic logic [1:0] enc_branch(input logic [6:0] v);
        return {^(v & TAPS_A), ^(v & TAPS_B)};
    endfunction

    function automatic logic [2:0] pat_len(input logic [2:0] cr);
        case (cr)
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd5;
            3'd4:    return 3'd7;
            default: return 3'd1;
        endcase
    endfunction

    // bit i = period position i
    function automatic logic [6:0] keep_a(input logic [2:0] cr);
        case (cr)
            3'd1:    return 7'b0000001;
            3'd2:    return 7'b0000101;
            3'd3:    return 7'b0010101;
            3'd4:    return 7'b1010001;
            default: return 7'b0000001;
        endcase
    endfunction

    function automatic logic [6:0] keep_b(input logic [2:0] cr);
        case (cr)
            3'd1:    return 7'b0000011;
            3'd2:    return 7'b0000011;
            3'd3:    return 7'b0001011;
            3'd4:    return 7'b0101111;
            default: return 7'b0000001;
        endcase
    endfunction

endpackage

// File: rtl/vit_depuncture.sv
module vit_depuncture
    import vit_k7_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [2:0] rate_i,
    input  logic       valid_i,
    input  logic       bit_i,
    output logic       pair_v_o,
    output chan_pair_t pair_o
);

    typedef struct packed {
        logic [2:0] pos;
        logic       half;
        logic       held;
        logic       pv;
        chan_pair_t pr;
    } dp_state_t;

    dp_state_t  q, d;
    logic [6:0] mask_a, mask_b;
    logic [2:0] plen;
    logic       ka, kb;

    always_comb begin
        mask_a = keep_a(rate_i);
        mask_b = keep_b(rate_i);
        plen   = pat_len(rate_i);
        ka     = mask_a[q.pos];
        kb     = mask_b[q.pos];
        d      = q;
        d.pv   = 1'b0;
        if (clr_i) begin
            d = '0;
        end else if (valid_i) begin
            if (!q.half && ka && kb) begin
                d.half = 1'b1;
                d.held = bit_i;
            end else begin
                d.pv = 1'b1;
                if (q.half) begin
                    d.pr   = '{a: q.held, b: bit_i, era_a: 1'b0, era_b: 1'b0};
                    d.half = 1'b0;
                end else if (ka) begin
                    d.pr = '{a: bit_i, b: 1'b0, era_a: 1'b0, era_b: 1'b1};
                end else begin
                    d.pr = '{a: 1'b0, b: bit_i, era_a: 1'b1, era_b: 1'b0};
                end
                d.pos = (q.pos + 3'd1 == plen) ? 3'd0 : q.pos + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pair_v_o = q.pv;
    assign pair_o   = q.pr;

    assert_idle_no_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !q.pv);

    assert_single_erasure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv |-> !(q.pr.era_a && q.pr.era_b));

endmodule

// File: rtl/vit_acs_regx.sv
module vit_acs_regx
    import vit_k7_pkg::*;
#(
    parameter int TB_DEPTH = 36,
    parameter int METRIC_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       step_i,
    input  chan_pair_t pair_i,
    output logic       dec_v_o,
    output logic       dec_bit_o
);

    localparam int NS        = NUM_STATES;
    localparam int SW        = STATE_W;
    localparam int FILL_W    = $clog2(TB_DEPTH + 1);
    localparam int INIT_BIAS = 1 << (METRIC_W - 3);
    localparam int HEADROOM  = 1 << (METRIC_W - 1);

    typedef struct packed {
        logic [NS-1:0][METRIC_W-1:0] pm;
        logic [NS-1:0][TB_DEPTH-1:0] surv;
        logic [FILL_W-1:0]           fill;
        logic                        dv;
        logic                        db;
    } acs_state_t;

    function automatic acs_state_t fresh_state();
        acs_state_t r;
        r = '0;
        for (int s = 1; s < NS; s++) r.pm[s] = METRIC_W'(INIT_BIAS);
        return r;
    endfunction

    acs_state_t q, d;

    logic [SW-1:0]       best_idx;
    logic [METRIC_W-1:0] best_pm;
    logic                pm_ok;

    always_comb begin
        best_idx = '0;
        best_pm  = q.pm[0];
        pm_ok    = 1'b1;
        for (int s = 0; s < NS; s++) begin
            if (q.pm[s] < best_pm) begin
                best_pm  = q.pm[s];
                best_idx = SW'(s);
            end
            if (q.pm[s] >= METRIC_W'(HEADROOM)) pm_ok = 1'b0;
        end
    end

    logic [SW-1:0]       sidx, p0, p1, psel;
    logic                u;
    logic [1:0]          br0, br1, cost0, cost1;
    logic [METRIC_W-1:0] c0, c1, csel;

    always_comb begin
        d     = q;
        d.dv  = 1'b0;
        sidx  = '0;
        p0    = '0;
        p1    = '0;
        psel  = '0;
        u     = 1'b0;
        br0   = '0;
        br1   = '0;
        cost0 = '0;
        cost1 = '0;
        c0    = '0;
        c1    = '0;
        csel  = '0;
        if (clr_i) begin
            d = fresh_state();
        end else if (step_i) begin
            d.dv = (q.fill == FILL_W'(TB_DEPTH));
            d.db = q.surv[best_idx][TB_DEPTH-1];
            if (q.fill != FILL_W'(TB_DEPTH)) d.fill = q.fill + 1'b1;
            for (int s = 0; s < NS; s++) begin
                sidx  = SW'(s);
                u     = sidx[SW-1];
                p0    = {sidx[SW-2:0], 1'b0};
                p1    = {sidx[SW-2:0], 1'b1};
                br0   = enc_branch({u, p0});
                br1   = enc_branch({u, p1});
                cost0 = (pair_i.era_a ? 2'd0 : {1'b0, br0[1] ^ pair_i.a})
                      + (pair_i.era_b ? 2'd0 : {1'b0, br0[0] ^ pair_i.b});
                cost1 = (pair_i.era_a ? 2'd0 : {1'b0, br1[1] ^ pair_i.a})
                      + (pair_i.era_b ? 2'd0 : {1'b0, br1[0] ^ pair_i.b});
                c0    = q.pm[p0] + METRIC_W'(cost0);
                c1    = q.pm[p1] + METRIC_W'(cost1);
                if (c1 < c0) begin
                    psel = p1;
                    csel = c1;
                end else begin
                    psel = p0;
                    csel = c0;
                end
                d.pm[sidx]   = csel - best_pm;
                d.surv[sidx] = {q.surv[psel][TB_DEPTH-2:0], u};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= fresh_state();
        else        q <= d;
    end

    assign dec_v_o   = q.dv;
    assign dec_bit_o = q.db;

    assert_metric_headroom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pm_ok);

    assert_dec_follows_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.dv |-> $past(step_i));

endmodule

// File: rtl/vit_ber_meter.sv
module vit_ber_meter
    import vit_k7_pkg::*;
#(
    parameter int TB_DEPTH = 36,
    parameter int WIN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  chan_pair_t       pair_i,
    input  logic             dec_v_i,
    input  logic             dec_bit_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             done_o,
    output logic [WIN_W+1:0] count_o
);

    localparam int CNT_W = WIN_W + 2;

    typedef struct packed {
        chan_pair_t [TB_DEPTH-1:0] line;
        chan_pair_t                held;
        logic [STATE_W-1:0]        enc;
        logic [CNT_W-1:0]          acc;
        logic [WIN_W-1:0]          wcnt;
        logic [CNT_W-1:0]          cnt;
        logic                      done;
    } ber_state_t;

    ber_state_t q, d;

    logic [6:0]       v;
    logic [1:0]       rb;
    logic [1:0]       miss;
    logic [CNT_W-1:0] sum;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        v      = {dec_bit_i, q.enc};
        rb     = enc_branch(v);
        miss   = ((!q.held.era_a && (rb[1] != q.held.a)) ? 2'd1 : 2'd0)
               + ((!q.held.era_b && (rb[0] != q.held.b)) ? 2'd1 : 2'd0);
        sum    = q.acc + CNT_W'(miss);
        if (clr_i) begin
            d = '0;
        end else begin
            if (step_i) begin
                d.line = {q.line[TB_DEPTH-2:0], pair_i};
                d.held = q.line[TB_DEPTH-1];
            end
            if (dec_v_i) begin
                d.enc = v[6:1];
                if ({1'b0, q.wcnt} + 1'b1 >= {1'b0, win_i}) begin
                    d.cnt  = sum;
                    d.done = 1'b1;
                    d.acc  = '0;
                    d.wcnt = '0;
                end else begin
                    d.acc  = sum;
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o  = q.done;
    assign count_o = q.cnt;

    assert_done_after_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(dec_v_i));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.done && !$past(clr_i)) |-> $stable(q.cnt));

endmodule

// File: rtl/vit_k7_decoder.sv
module vit_k7_decoder
    import vit_k7_pkg::*;
#(
    parameter int TB_DEPTH = 36,
    parameter int METRIC_W = 8,
    parameter int WIN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       rate_sel,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic [WIN_W-1:0] ber_window,
    output logic             out_valid,
    output logic             out_bit,
    output logic             ber_done,
    output logic [WIN_W+1:0] ber_count
);

    logic [2:0] rate_d, rate_q;
    logic       clr;
    logic       pair_v;
    chan_pair_t pair;

    always_comb begin
        rate_d = rate_sel;
        clr    = (rate_sel != rate_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= 3'd0;
        else        rate_q <= rate_d;
    end

    vit_depuncture u_dep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .rate_i   (rate_q),
        .valid_i  (in_valid),
        .bit_i    (in_bit),
        .pair_v_o (pair_v),
        .pair_o   (pair)
    );

    vit_acs_regx #(.TB_DEPTH(TB_DEPTH), .METRIC_W(METRIC_W)) u_acs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .step_i    (pair_v),
        .pair_i    (pair),
        .dec_v_o   (out_valid),
        .dec_bit_o (out_bit)
    );

    vit_ber_meter #(.TB_DEPTH(TB_DEPTH), .WIN_W(WIN_W)) u_ber (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .step_i    (pair_v),
        .pair_i    (pair),
        .dec_v_i   (out_valid),
        .dec_bit_i (out_bit),
        .win_i     (ber_window),
        .done_o    (ber_done),
        .count_o   (ber_count)
    );

    assert_clear_quiets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != rate_q) |=> (!out_valid && !ber_done && ber_count == '0));

endmodule

// File: tb/vit_k7_decoder_test.sv
module vit_k7_decoder_test;

    localparam int D  = 36;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    rate_sel;
    logic          in_valid;
    logic          in_bit;
    logic [WW-1:0] ber_window;
    logic          out_valid;
    logic          out_bit;
    logic          ber_done;
    logic [WW+1:0] ber_count;

    always #5 clk = ~clk;

    vit_k7_decoder #(.TB_DEPTH(D), .METRIC_W(8), .WIN_W(WW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .ber_window (ber_window),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .ber_done   (ber_done),
        .ber_count  (ber_count)
    );

    int total = 0;
    int bad = 0;
    bit sv [0:2];
    bit sb [0:2];
    bit sd [0:2];
    int sc [0:2];
    int last_cnt = 0;
    string bit_tag = "R4";
    logic [31:0] rs = 32'h1234abcd;
    bit src [0:4095];
    int errs [0:4095];
    string xpat [0:4] = '{"1", "10", "101", "10101", "1000101"};
    string ypat [0:4] = '{"1", "11", "110", "11010", "1111010"};

    function automatic bit rbit();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs[31];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: check what is due now, then drive the next input
    task automatic tick(input bit v, input bit b, input bit ev, input bit eb,
                        input bit dn, input int dc);
        @(negedge clk);
        chk(out_valid == sv[0], "R5 out_valid timing", int'(out_valid), int'(sv[0]));
        if (sv[0]) chk(out_bit == sb[0], {bit_tag, " decoded bit (R2,R3)"}, int'(out_bit), int'(sb[0]));
        chk(ber_done == sd[0], "R7 ber_done timing", int'(ber_done), int'(sd[0]));
        if (sd[0]) begin
            chk(int'(ber_count) == sc[0], "R7 window error count", int'(ber_count), sc[0]);
            last_cnt = sc[0];
        end else begin
            chk(int'(ber_count) == last_cnt, "R8 count held", int'(ber_count), last_cnt);
        end
        for (int k = 0; k < 2; k++) begin
            sv[k] = sv[k+1]; sb[k] = sb[k+1]; sd[k] = sd[k+1]; sc[k] = sc[k+1];
        end
        sv[2] = 1'b0; sb[2] = 1'b0; sd[2] = 1'b0; sc[2] = 0;
        sv[1] = ev;
        sb[1] = eb;
        sd[2] = dn;
        sc[2] = dc;
        in_valid = v;
        in_bit   = b;
    endtask

    task automatic run(input int r, input int nbits, input int espace, input int win,
                       input string tag);
        int st, chan, acc, per, pos, j;
        bit u, bx, by, ka, kb, ev, eb, dn, fb;
        logic [6:0] v;
        repeat (4) tick(1'b0, rbit(), 1'b0, 1'b0, 1'b0, 0);
        rate_sel   = 3'(r);
        ber_window = WW'(win);
        last_cnt   = 0;
        bit_tag    = tag;
        repeat (2) tick(1'b0, rbit(), 1'b0, 1'b0, 1'b0, 0);
        chk(out_valid == 1'b0 && ber_count == '0, "R9 cleared after rate change",
            int'(ber_count), 0);
        per = xpat[r].len();
        st = 0; chan = 0; acc = 0;
        for (int i = 0; i < nbits; i++) begin
            if (i % 7 == 6) tick(1'b0, rbit(), 1'b0, 1'b0, 1'b0, 0); // R10 idle cycle
            u = rbit();
            src[i] = u;
            v  = {u, 6'(st)};
            bx = ^(v & 7'o171);
            by = ^(v & 7'o133);
            st = int'(v[6:1]);
            pos = i % per;
            ka = (xpat[r][pos] == "1");
            kb = (ypat[r][pos] == "1");
            errs[i] = 0;
            if (ka) begin
                if (espace > 0 && chan % espace == espace - 1) begin bx = ~bx; errs[i]++; end
                chan++;
            end
            if (kb) begin
                if (espace > 0 && chan % espace == espace - 1) begin by = ~by; errs[i]++; end
                chan++;
            end
            ev = (i >= D); eb = 1'b0; dn = 1'b0;
            if (ev) begin
                j = i - D;
                eb = src[j];
                acc += errs[j];
                dn = ((j + 1) % win == 0);
            end
            if (ka && kb) tick(1'b1, bx, 1'b0, 1'b0, 1'b0, 0);
            fb = kb ? by : bx;
            tick(1'b1, fb, ev, eb, dn, dn ? acc : 0);
            if (dn) acc = 0;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        rate_sel = 3'd0; ber_window = WW'(50);
        for (int k = 0; k < 3; k++) begin sv[k] = 0; sb[k] = 0; sd[k] = 0; sc[k] = 0; end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && ber_done == 1'b0 && ber_count == '0, "R1 reset state",
            int'(ber_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && ber_done == 1'b0 && ber_count == '0, "R1 after release",
            int'(out_valid), 0);
        run(0, 400, 40, 50, "R6");   // 1/2 with sparse errors
        run(1, 300, 0, 60, "R4");    // 2/3 clean
        run(2, 400, 48, 64, "R6");   // 3/4 with sparse errors
        run(3, 300, 0, 40, "R4");    // 5/6 clean
        run(4, 300, 0, 70, "R4");    // 7/8 clean, back-to-back pairs
        run(0, 200, 0, 1, "R4");     // R8 window of one bit, R9 clear from 7/8
        repeat (4) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule